// File: doc/BRIEF.md
# Local-to-PCI Address Window Translator

This block turns requests from a simple local memory-mapped port into single requests on an abstract PCI-side port. A local request whose address falls in the 1 GB window starting at 0x80000000 is forwarded. All other local requests finish at once with an error response. A mode input picks the kind of cycle for forwarded requests. When the mode input is low, the request becomes a memory cycle: the low 30 address bits are passed through, and a 2-bit input supplies the top two bits. When the mode input is high, the request becomes a configuration cycle. The block decodes a device number, a function number and a register offset from the local address, and builds a PCI address that holds a one-hot device-select bit.

Only one transaction runs at a time. Local ready stays low until the PCI side reports completion or an abort. The block keeps sticky note of a bus abort, which stays set until it is cleared by a write-one-to-clear pulse. An aborted read returns all ones. Sub-word accesses are steered onto byte lanes. I/O-space cycles are never produced, because the command is always memory or configuration.

Top module: `pci_window_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `pci_valid`, `rsp_valid` and `abort_flag` are all 0.
- R2: A request is forwarded only if `req_addr[31:30]` is 2'b10. Any other request starts no PCI cycle. In the cycle after it is accepted, that request gets `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0xFFFFFFFF.
- R3: In memory mode (`cfg_sel`=0), `pci_cfg`=0 and `pci_addr` = {`hi_sel`, `req_addr[29:2]`, 2'b00}. `pci_write` follows `req_write`.
- R4: In configuration mode (`cfg_sel`=1), `pci_cfg`=1. The device number is `req_addr[15:11]`, the function is `req_addr[10:8]` and the dword offset is `req_addr[7:2]`. `pci_addr` = (1 << (13+device)) | function<<8 | offset<<2.
- R5: In configuration mode, a request is rejected with no PCI cycle when `req_addr[29:20]` is not zero (the 1 MB aperture) or when the device number is above 18. The response is the same as in R2.
- R6: Sizes are encoded as 0 for a byte, 1 for a halfword, and 2 or 3 for a word. For a byte the lane is `req_addr[1:0]`, and for a halfword it is `req_addr[1:0]`. `pci_be` is 4'b0001 or 4'b0011 shifted left by the lane, and 4'b1111 for a word. `pci_wdata` is `req_wdata` shifted left by 8×lane, and a word uses no shift.
- R7: A completed read returns `rsp_rdata` = (`pci_rdata` >> 8×lane), masked to 8, 16 or 32 bits by the size. `rsp_valid` is 1 in the cycle after `pci_done`, with `rsp_err`=0.
- R8: While `pci_valid` is 1, `req_ready` is 0, the PCI request outputs hold steady and new local requests are ignored.
- R9: `pci_abort` sets `abort_flag`. The flag is cleared only by `abort_clr`. If an abort and a clear fall in the same cycle, the flag stays set.
- R10: An aborted transaction responds with `rsp_err`=1. An aborted read also returns `rsp_rdata`=0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | 1 selects configuration cycles, 0 selects memory cycles |
| hi_sel | input | 2 | Top two PCI address bits for memory cycles |
| abort_clr | input | 1 | Write-one-to-clear pulse for the abort flag |
| abort_flag | output | 1 | Sticky bus-abort status |
| req_valid | input | 1 | Local request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Local address |
| req_wdata | input | 32 | Local write data, right-aligned |
| req_ready | output | 1 | Block idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is a reject or an abort |
| rsp_rdata | output | 32 | Read data, right-aligned |
| pci_valid | output | 1 | PCI-side request pending |
| pci_cfg | output | 1 | Command type: 1 configuration, 0 memory |
| pci_write | output | 1 | PCI request is a write |
| pci_addr | output | 32 | PCI bus address |
| pci_be | output | 4 | PCI byte enables |
| pci_wdata | output | 32 | Lane-aligned write data |
| pci_rdata | input | 32 | PCI read data |
| pci_done | input | 1 | PCI request completed |
| pci_abort | input | 1 | PCI request ended in an abort |

## Verification
The write-one-to-clear of the abort flag and a new abort arriving from the PCI side can land on the same clock edge. The bench provokes this by asserting `abort_clr` and `pci_abort` together while a read is pending. It judges the result by checking that `abort_flag` is still 1 afterwards, and that it falls only after a later clear issued alone. A local request strobe that arrives while a transaction is pending can fall in the same cycle as that transaction's completion. The bench checks that such a strobe leaves the PCI outputs unchanged and starts no second cycle.

// File: rtl/pci_window_xlate.sv
module pci_window_xlate #(
  parameter int SEL_BASE  = 13,
  parameter int DEV_MAX   = 18,
  parameter int APER_BITS = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_sel,
  input  logic [1:0]  hi_sel,
  input  logic        abort_clr,
  output logic        abort_flag,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        pci_valid,
  output logic        pci_cfg,
  output logic        pci_write,
  output logic [31:0] pci_addr,
  output logic [3:0]  pci_be,
  output logic [31:0] pci_wdata,
  input  logic [31:0] pci_rdata,
  input  logic        pci_done,
  input  logic        pci_abort
);

  logic [4:0]  dev;
  logic        in_win, cfg_ok, fwd;
  logic [1:0]  lane, lane_q, size_q;
  logic [5:0]  sel_pos;
  logic [31:0] cfg_addr, mem_addr, rd_shift, rd_ext;
  logic [3:0]  be_n;

  assign dev      = req_addr[15:11];
  assign in_win   = (req_addr[31:30] == 2'b10);
  assign cfg_ok   = (req_addr[29:APER_BITS] == '0) && (int'(dev) <= DEV_MAX);
  assign fwd      = in_win && (!cfg_sel || cfg_ok);
  assign lane     = req_size[1] ? 2'd0 : req_addr[1:0];
  assign sel_pos  = {1'b0, dev} + 6'(SEL_BASE);
  assign cfg_addr = (32'd1 << sel_pos) | {21'd0, req_addr[10:8], req_addr[7:2], 2'b00};
  assign mem_addr = {hi_sel, req_addr[29:2], 2'b00};
  assign req_ready = !pci_valid;

  always_comb begin
    case (req_size)
      2'd0:    be_n = 4'b0001 << lane;
      2'd1:    be_n = 4'b0011 << lane;
      default: be_n = 4'b1111;
    endcase
  end

  assign rd_shift = pci_rdata >> {lane_q, 3'b000};
  always_comb begin
    case (size_q)
      2'd0:    rd_ext = {24'd0, rd_shift[7:0]};
      2'd1:    rd_ext = {16'd0, rd_shift[15:0]};
      default: rd_ext = rd_shift;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_flag <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      pci_valid  <= 1'b0;
      pci_cfg    <= 1'b0;
      pci_write  <= 1'b0;
      pci_addr   <= '0;
      pci_be     <= '0;
      pci_wdata  <= '0;
      lane_q     <= '0;
      size_q     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (abort_clr) abort_flag <= 1'b0;
      if (!pci_valid) begin
        if (req_valid) begin
          if (fwd) begin
            pci_valid <= 1'b1;
            pci_cfg   <= cfg_sel;
            pci_write <= req_write;
            pci_addr  <= cfg_sel ? cfg_addr : mem_addr;
            pci_be    <= be_n;
            pci_wdata <= req_wdata << {lane, 3'b000};
            lane_q    <= lane;
            size_q    <= req_size;
          end else begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '1;
          end
        end
      end else if (pci_abort || pci_done) begin
        pci_valid <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_err   <= pci_abort;
        rsp_rdata <= pci_abort ? '1 : rd_ext;
        if (pci_abort) abort_flag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pci_window_xlate_chk.sv
module pci_window_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        abort_clr,
  input logic        abort_flag,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        pci_valid,
  input logic        pci_cfg,
  input logic        pci_write,
  input logic [31:0] pci_addr,
  input logic        pci_done,
  input logic        pci_abort
);

  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_valid |-> req_ready);

  a_r2_outside_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[31:30] != 2'b10) |=> (!pci_valid && rsp_valid && rsp_err));

  a_r4_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_valid && pci_cfg) |-> ($countones(pci_addr[31:13]) == 1));

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_valid && !pci_done && !pci_abort) |=> (pci_valid && $stable(pci_addr) && $stable(pci_cfg) && $stable(pci_write)));

  a_r9_abort_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_valid && pci_abort) |=> abort_flag);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !abort_clr) |=> abort_flag);

  a_r10_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_valid && pci_abort && !pci_write) |=> (rsp_valid && rsp_err && rsp_rdata == 32'hFFFF_FFFF));

endmodule

bind pci_window_xlate pci_window_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort_clr(abort_clr), .abort_flag(abort_flag),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .pci_valid(pci_valid), .pci_cfg(pci_cfg), .pci_write(pci_write),
  .pci_addr(pci_addr), .pci_done(pci_done), .pci_abort(pci_abort)
);

// File: tb/pci_window_xlate_test.sv
module pci_window_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [1:0]  hi_sel = 2'b00;
  logic        abort_clr = 1'b0;
  logic        abort_flag;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        pci_valid, pci_cfg, pci_write;
  logic [31:0] pci_addr, pci_wdata;
  logic [3:0]  pci_be;
  logic [31:0] pci_rdata = '0;
  logic        pci_done = 1'b0;
  logic        pci_abort = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pci_window_xlate uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .hi_sel(hi_sel),
    .abort_clr(abort_clr), .abort_flag(abort_flag),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .pci_valid(pci_valid), .pci_cfg(pci_cfg), .pci_write(pci_write),
    .pci_addr(pci_addr), .pci_be(pci_be), .pci_wdata(pci_wdata),
    .pci_rdata(pci_rdata), .pci_done(pci_done), .pci_abort(pci_abort)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_bus(input logic [31:0] rd, input logic ab, input logic clr);
    @(negedge clk);
    pci_rdata = rd; pci_done = !ab; pci_abort = ab; abort_clr = clr;
    @(negedge clk);
    pci_done = 1'b0; pci_abort = 1'b0; abort_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    check("R1 pci_valid", {31'd0, pci_valid}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 abort_flag", {31'd0, abort_flag}, 32'd0);
  endtask

  task automatic t_outside();
    cfg_sel = 1'b0;
    issue(1'b0, 2'd2, 32'h4000_1000, 32'd0);
    check("R2 no cycle", {31'd0, pci_valid}, 32'd0);
    check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check("R2 rsp_err", {31'd0, rsp_err}, 32'd1);
    check("R2 ones", rsp_rdata, 32'hFFFF_FFFF);
    issue(1'b1, 2'd2, 32'hC000_0000, 32'h1234);
    check("R2 upper edge rejected", {31'd0, pci_valid}, 32'd0);
  endtask

  task automatic t_mem_write();
    cfg_sel = 1'b0; hi_sel = 2'b01;
    issue(1'b1, 2'd0, 32'hBFFF_FFFF, 32'h0000_00A5);
    check("R3 addr", pci_addr, 32'h7FFF_FFFC);
    check("R3 cmd", {30'd0, pci_cfg, pci_write}, 32'd1);
    check("R6 byte be", {28'd0, pci_be}, 32'h8);
    check("R6 byte data", pci_wdata, 32'hA500_0000);
    check("R8 ready low", {31'd0, req_ready}, 32'd0);
    finish_bus(32'd0, 1'b0, 1'b0);
    check("R7 write done", {30'd0, rsp_valid, rsp_err}, 32'd2);
    hi_sel = 2'b11;
    issue(1'b1, 2'd1, 32'h8000_0012, 32'h0000_BEEF);
    check("R3 addr hi", pci_addr, 32'hC000_0010);
    check("R6 half be", {28'd0, pci_be}, 32'hC);
    check("R6 half data", pci_wdata, 32'hBEEF_0000);
    finish_bus(32'd0, 1'b0, 1'b0);
    issue(1'b1, 2'd2, 32'h8000_0023, 32'hCAFE_F00D);
    check("R6 word be", {28'd0, pci_be}, 32'hF);
    check("R6 word data", pci_wdata, 32'hCAFE_F00D);
    finish_bus(32'd0, 1'b0, 1'b0);
  endtask

  task automatic t_mem_read();
    cfg_sel = 1'b0; hi_sel = 2'b10;
    issue(1'b0, 2'd0, 32'h8000_0101, 32'd0);
    check("R3 read cmd", {30'd0, pci_cfg, pci_write}, 32'd0);
    finish_bus(32'h1122_3344, 1'b0, 1'b0);
    check("R7 byte lane1", rsp_rdata, 32'h0000_0033);
    check("R7 ok", {30'd0, rsp_valid, rsp_err}, 32'd2);
    issue(1'b0, 2'd1, 32'h8000_0102, 32'd0);
    finish_bus(32'h1122_3344, 1'b0, 1'b0);
    check("R7 half upper", rsp_rdata, 32'h0000_1122);
    issue(1'b0, 2'd2, 32'h8000_0100, 32'd0);
    finish_bus(32'h1122_3344, 1'b0, 1'b0);
    check("R7 word", rsp_rdata, 32'h1122_3344);
  endtask

  task automatic t_cfg();
    logic [31:0] exp;
    cfg_sel = 1'b1;
    issue(1'b0, 2'd2, 32'h8000_0000 | (32'd3 << 11) | (32'd2 << 8) | 32'h10, 32'd0);
    exp = (32'd1 << 16) | (32'd2 << 8) | 32'h10;
    check("R4 cfg addr dev3", pci_addr, exp);
    check("R4 cfg cmd", {31'd0, pci_cfg}, 32'd1);
    finish_bus(32'hFF18_168C, 1'b0, 1'b0);
    check("R7 cfg read", rsp_rdata, 32'hFF18_168C);
    issue(1'b1, 2'd2, 32'h8000_0000 | (32'd18 << 11) | 32'hFC, 32'h5);
    exp = (32'd1 << 31) | 32'hFC;
    check("R4 cfg addr dev18", pci_addr, exp);
    finish_bus(32'd0, 1'b0, 1'b0);
    issue(1'b0, 2'd2, 32'h8000_0000 | (32'd19 << 11), 32'd0);
    check("R5 dev19 no cycle", {31'd0, pci_valid}, 32'd0);
    check("R5 dev19 reject", {29'd0, rsp_valid, rsp_err, rsp_rdata[0]}, 32'd7);
    issue(1'b0, 2'd2, 32'h8010_0000, 32'd0);
    check("R5 aperture no cycle", {31'd0, pci_valid}, 32'd0);
    check("R5 aperture ones", rsp_rdata, 32'hFFFF_FFFF);
    cfg_sel = 1'b0;
    issue(1'b0, 2'd2, 32'h8010_0000, 32'd0);
    check("R5 mem mode forwards", {31'd0, pci_valid}, 32'd1);
    finish_bus(32'd0, 1'b0, 1'b0);
  endtask

  task automatic t_busy_ignore();
    cfg_sel = 1'b0; hi_sel = 2'b00;
    issue(1'b0, 2'd2, 32'h8000_0400, 32'd0);
    issue(1'b1, 2'd2, 32'h8000_0800, 32'd9);
    check("R8 addr held", pci_addr, 32'h0000_0400);
    check("R8 write held", {31'd0, pci_write}, 32'd0);
    @(negedge clk);
    pci_rdata = 32'h77; pci_done = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h8000_0900;
    @(negedge clk);
    pci_done = 1'b0; req_valid = 1'b0;
    check("R8 no second cycle", {31'd0, pci_valid}, 32'd0);
    check("R8 response", rsp_rdata, 32'h77);
  endtask

  task automatic t_abort();
    issue(1'b0, 2'd0, 32'h8000_0003, 32'd0);
    finish_bus(32'h1234_5678, 1'b1, 1'b1);
    check("R10 abort ones", rsp_rdata, 32'hFFFF_FFFF);
    check("R10 abort err", {30'd0, rsp_valid, rsp_err}, 32'd3);
    check("R9 set wins over clear", {31'd0, abort_flag}, 32'd1);
    repeat (3) @(negedge clk);
    check("R9 sticky", {31'd0, abort_flag}, 32'd1);
    abort_clr = 1'b1;
    @(negedge clk);
    abort_clr = 1'b0;
    check("R9 cleared", {31'd0, abort_flag}, 32'd0);
    issue(1'b1, 2'd2, 32'h8000_0004, 32'd1);
    finish_bus(32'd0, 1'b1, 1'b0);
    check("R10 write abort err", {30'd0, rsp_valid, rsp_err}, 32'd3);
    check("R9 write abort sets", {31'd0, abort_flag}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outside();
    t_mem_write();
    t_mem_read();
    t_cfg();
    t_busy_ignore();
    t_abort();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule